// File: doc/BRIEF.md
# CSMA-CA Transmit Retry Sequencer

This block carries one frame from "send requested" to a final outcome. On a start command it performs unslotted carrier-sense multiple access with collision avoidance. It waits a random number of unit periods and then asks an external detector whether the channel is clear. A busy channel widens the random window and repeats the wait. A clear channel pulses a transmit-start output to the modem.

When the caller asks for an acknowledgement, the block then waits for one for a fixed number of unit periods. If no acknowledgement arrives, the whole channel-access attempt starts again. The block gives up after a set number of busy assessments, or after a set number of acknowledgement timeouts. In every case it posts a 2-bit outcome code and raises a sticky interrupt flag.

Two configuration bytes set the limits and are captured when a sequence starts. A free-running 16-bit LFSR supplies the backoff values. A unit-period tick input paces both the backoff and the acknowledgement timer.

Top module: `csma_seq_top`

## Requirements
- R1: Configuration is captured at start. The frame-retry limit is `retry_cfg_i[3:0]` and the CCA-retry limit is `retry_cfg_i[6:4]`. The maximum backoff exponent is `backoff_cfg_i[3:0]` and the minimum is `backoff_cfg_i[7:4]`. Valid settings have min ≤ max ≤ 8 and CCA-retry limit ≤ 5.
- R2: Each backoff waits a random count of unit ticks in the range 0 to 2^BE−1. With BE = 0 the CCA request follows the start within a few cycles.
- R3: BE starts at the minimum and grows by one after each busy CCA, capped at the maximum. With min = max = 2, successive CCA requests are never more than 3 ticks of backoff apart.
- R4: A clear CCA pulses `tx_start_o` for one cycle. The outcome is code 0 when an acknowledgement without its pending flag arrives, or as soon as `tx_done_i` is seen if `ack_req_i` was low at start.
- R5: An acknowledgement received with `ack_pend_i` high yields code 1.
- R6: The sequence ends with code 2 once the number of busy CCAs exceeds the CCA-retry limit. That takes limit+1 CCA requests, with no transmission.
- R7: An acknowledgement timeout after ACK_UNITS ticks restarts channel access from the minimum BE. Once the timeouts exceed the frame-retry limit, the outcome is code 3, after limit+1 transmissions.
- R8: `irq_o` is set when the outcome is posted and stays set until `irq_clr_i` is pulsed (write-one-to-clear). Setting wins over clearing in the same cycle.
- R9: A start that arrives while a sequence is running is ignored. It causes no extra transmissions, no extra CCA requests and no extra outcome.
- R10: `busy_o` is high from the cycle after an accepted start until the outcome is posted. `result_o` changes only in the cycle `busy_o` falls. `cca_req_o` and `tx_start_o` pulse only while busy, and never together.
- R11: After reset, `busy_o`, `irq_o`, `cca_req_o`, `tx_start_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a sequence (one-cycle pulse) |
| retry_cfg_i | input | 8 | Frame-retry limit [3:0], CCA-retry limit [6:4] |
| backoff_cfg_i | input | 8 | Max BE [3:0], min BE [7:4] |
| ack_req_i | input | 1 | Wait for acknowledgement after transmission |
| unit_tick_i | input | 1 | One pulse per backoff unit period |
| cca_done_i | input | 1 | CCA result is valid |
| cca_clear_i | input | 1 | Channel clear (qualified by cca_done_i) |
| tx_done_i | input | 1 | Modem finished sending the frame |
| ack_rx_i | input | 1 | Acknowledgement received |
| ack_pend_i | input | 1 | Frame-pending flag of the acknowledgement |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt flag |
| cca_req_o | output | 1 | Request a channel assessment (pulse) |
| tx_start_o | output | 1 | Start frame transmission (pulse) |
| busy_o | output | 1 | Sequence in progress |
| irq_o | output | 1 | Sticky completion interrupt |
| result_o | output | 2 | Outcome: 0 ok, 1 ok with pending, 2 access failure, 3 no ack |

## Verification
The hardest situation to reach is the two-level retry, where every transmission in a run times out. Each timeout must throw the sequencer back into a fresh channel access with the backoff exponent reset. The bench reaches it with a responder that answers every CCA as clear but never sends an acknowledgement. It then checks that exactly limit+1 transmissions and limit+1 CCA requests occur before code 3. The random backoff makes exact timing unpredictable from outside, so the exponent behaviour is bounded instead. With equal min and max exponents, the bench measures the largest gap between CCA requests in an all-busy run.

// File: rtl/csma_seq_pkg.sv
package csma_seq_pkg;
    localparam int CFG_W = 8;
    localparam logic [1:0] RES_OK      = 2'd0;
    localparam logic [1:0] RES_OK_PEND = 2'd1;
    localparam logic [1:0] RES_NO_CH   = 2'd2;
    localparam logic [1:0] RES_NO_ACK  = 2'd3;

    typedef enum logic [2:0] {
        S_IDLE, S_BACKOFF, S_CCA_WAIT, S_TX_WAIT, S_ACK_WAIT
    } seq_state_e;
endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
    parameter int               W    = 16,
    parameter logic [W-1:0]     TAPS = 16'hB400,
    parameter logic [W-1:0]     SEED = 16'hACE1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    output logic [W-1:0] rnd_o
);
    logic [W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q >> 1;
        if (lfsr_q[0]) lfsr_d = lfsr_d ^ TAPS;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lfsr_q <= SEED;
        else         lfsr_q <= lfsr_d;
    end

    assign rnd_o = lfsr_q;

    a_r2_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lfsr_q != '0);
endmodule

// File: rtl/csma_tick_cnt.sv
module csma_tick_cnt #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         tick_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                       cnt_d = load_val_i;
        else if (tick_i && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    a_r2_count_down_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(load_i) |-> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/csma_seq_top.sv
module csma_seq_top
    import csma_seq_pkg::*;
#(
    parameter int BO_W      = 8,
    parameter int ACK_UNITS = 8,
    parameter int RND_W     = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic [7:0] retry_cfg_i,
    input  logic [7:0] backoff_cfg_i,
    input  logic       ack_req_i,
    input  logic       unit_tick_i,
    input  logic       cca_done_i,
    input  logic       cca_clear_i,
    input  logic       tx_done_i,
    input  logic       ack_rx_i,
    input  logic       ack_pend_i,
    input  logic       irq_clr_i,
    output logic       cca_req_o,
    output logic       tx_start_o,
    output logic       busy_o,
    output logic       irq_o,
    output logic [1:0] result_o
);
    localparam int ACK_W = $clog2(ACK_UNITS + 1);

    typedef struct packed {
        seq_state_e  st;
        logic [2:0]  nb;
        logic [3:0]  nr;
        logic [3:0]  be;
        logic [3:0]  frame_lim;
        logic [2:0]  cca_lim;
        logic [3:0]  be_min;
        logic [3:0]  be_max;
        logic        ack_req;
        logic        cca_req;
        logic        tx_start;
        logic        busy;
        logic        irq;
        logic [1:0]  result;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [RND_W-1:0] rnd;
    logic             bo_load, bo_zero, ack_load, ack_zero;
    logic [3:0]       bo_be;
    logic [BO_W-1:0]  bo_val;
    logic             unused_cfg;

    assign unused_cfg = retry_cfg_i[7];

    csma_lfsr #(.W(RND_W)) u_lfsr (
        .clk_i (clk_i), .rst_ni (rst_ni), .rnd_o (rnd)
    );

    csma_tick_cnt #(.W(BO_W)) u_backoff (
        .clk_i (clk_i), .rst_ni (rst_ni), .load_i (bo_load),
        .load_val_i (bo_val), .tick_i (unit_tick_i), .zero_o (bo_zero)
    );

    csma_tick_cnt #(.W(ACK_W)) u_ack_tmr (
        .clk_i (clk_i), .rst_ni (rst_ni), .load_i (ack_load),
        .load_val_i (ACK_W'(ACK_UNITS)), .tick_i (unit_tick_i), .zero_o (ack_zero)
    );

    // Random value masked to 2^BE-1
    always_comb begin
        if (int'(bo_be) >= BO_W) bo_val = rnd[BO_W-1:0];
        else                     bo_val = rnd[BO_W-1:0] & BO_W'((1 << bo_be) - 1);
    end

    always_comb begin
        r_d      = r_q;
        r_d.cca_req  = 1'b0;
        r_d.tx_start = 1'b0;
        bo_load  = 1'b0;
        bo_be    = r_q.be;
        ack_load = 1'b0;
        if (irq_clr_i) r_d.irq = 1'b0;

        unique case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    r_d.frame_lim = retry_cfg_i[3:0];
                    r_d.cca_lim   = retry_cfg_i[6:4];
                    r_d.be_max    = backoff_cfg_i[3:0];
                    r_d.be_min    = backoff_cfg_i[7:4];
                    r_d.be        = backoff_cfg_i[7:4];
                    r_d.ack_req   = ack_req_i;
                    r_d.nb        = '0;
                    r_d.nr        = '0;
                    r_d.busy      = 1'b1;
                    r_d.st        = S_BACKOFF;
                    bo_be         = backoff_cfg_i[7:4];
                    bo_load       = 1'b1;
                end
            end
            S_BACKOFF: begin
                if (bo_zero) begin
                    r_d.cca_req = 1'b1;
                    r_d.st      = S_CCA_WAIT;
                end
            end
            S_CCA_WAIT: begin
                if (cca_done_i) begin
                    if (cca_clear_i) begin
                        r_d.tx_start = 1'b1;
                        r_d.st       = S_TX_WAIT;
                    end else if (r_q.nb == r_q.cca_lim) begin
                        r_d.result = RES_NO_CH;
                        r_d.irq    = 1'b1;
                        r_d.busy   = 1'b0;
                        r_d.st     = S_IDLE;
                    end else begin
                        r_d.nb  = r_q.nb + 1'b1;
                        r_d.be  = (r_q.be < r_q.be_max) ? r_q.be + 1'b1 : r_q.be_max;
                        bo_be   = r_d.be;
                        bo_load = 1'b1;
                        r_d.st  = S_BACKOFF;
                    end
                end
            end
            S_TX_WAIT: begin
                if (tx_done_i) begin
                    if (r_q.ack_req) begin
                        ack_load = 1'b1;
                        r_d.st   = S_ACK_WAIT;
                    end else begin
                        r_d.result = RES_OK;
                        r_d.irq    = 1'b1;
                        r_d.busy   = 1'b0;
                        r_d.st     = S_IDLE;
                    end
                end
            end
            S_ACK_WAIT: begin
                if (ack_rx_i) begin
                    r_d.result = ack_pend_i ? RES_OK_PEND : RES_OK;
                    r_d.irq    = 1'b1;
                    r_d.busy   = 1'b0;
                    r_d.st     = S_IDLE;
                end else if (ack_zero) begin
                    if (r_q.nr == r_q.frame_lim) begin
                        r_d.result = RES_NO_ACK;
                        r_d.irq    = 1'b1;
                        r_d.busy   = 1'b0;
                        r_d.st     = S_IDLE;
                    end else begin
                        r_d.nr  = r_q.nr + 1'b1;
                        r_d.nb  = '0;
                        r_d.be  = r_q.be_min;
                        bo_be   = r_q.be_min;
                        bo_load = 1'b1;
                        r_d.st  = S_BACKOFF;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{st: S_IDLE, default: '0};
        else         r_q <= r_d;
    end

    assign cca_req_o  = r_q.cca_req;
    assign tx_start_o = r_q.tx_start;
    assign busy_o     = r_q.busy;
    assign irq_o      = r_q.irq;
    assign result_o   = r_q.result;

    a_r10_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$fell(busy_o) |-> $stable(result_o));
    a_r10_pulse_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cca_req_o || tx_start_o) |-> busy_o);
    a_r10_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({cca_req_o, tx_start_o}));
    a_r8_irq_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> irq_o);
    a_r9_rise_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(start_i));
    a_r6_nb_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.nb <= r_q.cca_lim);
    a_r7_nr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.nr <= r_q.frame_lim);
    a_r3_be_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (r_q.be <= r_q.be_max || r_q.be == r_q.be_min));
endmodule

// File: tb/sim_csma_seq_top.sv
module sim_csma_seq_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, ack_req = 0, tick = 0, cca_done = 0, cca_clear = 0;
    logic tx_done = 0, ack_rx = 0, ack_pend = 0, irq_clr = 0;
    logic [7:0] rcfg = 0, bcfg = 0;
    logic cca_req, tx_start, busy, irq;
    logic [1:0] result;

    always #2.5 clk = ~clk;

    csma_seq_top u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .retry_cfg_i(rcfg),
        .backoff_cfg_i(bcfg), .ack_req_i(ack_req), .unit_tick_i(tick),
        .cca_done_i(cca_done), .cca_clear_i(cca_clear), .tx_done_i(tx_done),
        .ack_rx_i(ack_rx), .ack_pend_i(ack_pend), .irq_clr_i(irq_clr),
        .cca_req_o(cca_req), .tx_start_o(tx_start), .busy_o(busy),
        .irq_o(irq), .result_o(result)
    );

    typedef struct {
        logic [1:0] code;
        int         n_tx;
        int         n_cca;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int n_checks = 0, n_fail = 0;
    int n_tx = 0, n_cca = 0, n_done = 0;
    int busy_k = 0, give_ack = 0, give_pend = 0, cca_idx = 0;
    longint cyc = 0, last_cca = 0, max_gap = 0, t_start = 0, first_cca = -1;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    initial forever begin @(posedge clk); cyc++; end

    initial forever begin
        repeat (3) @(negedge clk);
        tick = 1; @(negedge clk); tick = 0;
    end

    // CCA responder
    initial forever begin
        @(negedge clk);
        if (cca_req) begin
            @(negedge clk);
            cca_done = 1; cca_clear = (cca_idx >= busy_k); cca_idx++;
            @(negedge clk);
            cca_done = 0; cca_clear = 0;
        end
    end

    // Modem / acknowledgement responder
    initial forever begin
        @(negedge clk);
        if (tx_start) begin
            repeat (3) @(negedge clk);
            tx_done = 1; @(negedge clk); tx_done = 0;
            if (give_ack != 0) begin
                @(negedge clk);
                ack_rx = 1; ack_pend = (give_pend != 0);
                @(negedge clk);
                ack_rx = 0; ack_pend = 0;
            end
        end
    end

    // Monitor / scoreboard
    initial begin : mon
        logic prev_busy;
        prev_busy = 0;
        forever begin
            @(negedge clk);
            if (cca_req) begin
                if (n_cca > 0 && cyc - last_cca > max_gap) max_gap = cyc - last_cca;
                if (first_cca < 0) first_cca = cyc - t_start;
                last_cca = cyc; n_cca++;
            end
            if (tx_start) n_tx++;
            if (prev_busy && !busy) begin
                n_done++;
                if (sb_q.size() == 0) check(0, "R9 unexpected outcome", n_done, 0);
                else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(result == e.code, {e.tag, " code"}, result, e.code);
                    check(n_tx == e.n_tx, {e.tag, " tx count"}, n_tx, e.n_tx);
                    check(n_cca == e.n_cca, {e.tag, " cca count"}, n_cca, e.n_cca);
                end
            end
            prev_busy = busy;
        end
    end

    task automatic launch(input logic [7:0] rc, input logic [7:0] bc, input logic ar,
                          input int bk, input int ga, input int gp,
                          input logic [1:0] code, input int etx, input int ecca, input string tag);
        exp_t e;
        e.code = code; e.n_tx = etx; e.n_cca = ecca; e.tag = tag;
        sb_q.push_back(e);
        rcfg = rc; bcfg = bc; ack_req = ar;
        busy_k = bk; give_ack = ga; give_pend = gp; cca_idx = 0;
        n_tx = 0; n_cca = 0; max_gap = 0; first_cca = -1; t_start = cyc;
        start = 1; @(negedge clk); start = 0;
    endtask

    task automatic finish_seq();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        irq_clr = 1; @(negedge clk); irq_clr = 0; @(negedge clk);
    endtask

    task automatic run(input logic [7:0] rc, input logic [7:0] bc, input logic ar,
                       input int bk, input int ga, input int gp,
                       input logic [1:0] code, input int etx, input int ecca, input string tag);
        launch(rc, bc, ar, bk, ga, gp, code, etx, ecca, tag);
        @(negedge clk);
        finish_seq();
    endtask

    initial begin
        fork
            begin : tests
                repeat (4) @(negedge clk);
                check(busy == 0 && irq == 0 && result == 0 && cca_req == 0 && tx_start == 0,
                      "R11 reset state", {busy, irq, result}, 0);
                rst_n = 1;
                repeat (2) @(negedge clk);

                // R4/R1: limits 4 CCA, 3 frames, BE 3..5, clear channel, plain ack
                run(8'h43, 8'h35, 1, 0, 1, 0, 2'd0, 1, 1, "R4 ack ok");
                // R5: pending acknowledgement
                run(8'h43, 8'h35, 1, 0, 1, 1, 2'd1, 1, 1, "R5 ack pending");
                // R4: no acknowledgement requested
                run(8'h43, 8'h35, 0, 0, 0, 0, 2'd0, 1, 1, "R4 no ack wanted");
                // R6/R1: always busy, CCA limit 4 -> 5 requests
                run(8'h43, 8'h35, 1, 99, 1, 0, 2'd2, 0, 5, "R6 R1 cca limit 4");
                // R6: CCA limit 0 -> single request
                run(8'h03, 8'h35, 1, 99, 1, 0, 2'd2, 0, 1, "R6 cca limit 0");
                // R6 boundary: busy 5 times, limit 5 -> succeeds on 6th
                run(8'h53, 8'h24, 1, 5, 1, 0, 2'd0, 1, 6, "R6 limit 5 edge");
                // R7: no ack, frame limit 2 -> 3 transmissions
                run(8'h42, 8'h23, 1, 0, 0, 0, 2'd3, 3, 3, "R7 frame limit 2");
                // R7: frame limit 0 -> 1 transmission
                run(8'h40, 8'h23, 1, 0, 0, 0, 2'd3, 1, 1, "R7 frame limit 0");

                // R2: BE 0 -> prompt first CCA
                launch(8'h40, 8'h00, 0, 0, 0, 0, 2'd0, 1, 1, "R2 be zero");
                @(negedge clk);
                while (busy) @(negedge clk);
                check(first_cca >= 0 && first_cca <= 4, "R2 be zero latency", first_cca, 4);
                finish_seq();

                // R3: BE pinned at 2, always busy -> bounded gaps
                launch(8'h50, 8'h22, 1, 99, 1, 0, 2'd2, 0, 6, "R3 be cap");
                @(negedge clk);
                while (busy) @(negedge clk);
                check(max_gap <= 22, "R3 backoff gap bound", max_gap, 22);
                finish_seq();

                // R9: second start mid-sequence is ignored
                launch(8'h42, 8'h23, 1, 0, 0, 0, 2'd3, 3, 3, "R9 restart ignored");
                repeat (20) @(negedge clk);
                check(busy == 1, "R10 busy held", busy, 1);
                start = 1; @(negedge clk); start = 0;
                @(negedge clk);
                while (busy) @(negedge clk);
                repeat (3) @(negedge clk);
                // R8: irq sticky until cleared
                check(irq == 1, "R8 irq sticky", irq, 1);
                check(result == 2'd3, "R10 result held after done", result, 3);
                irq_clr = 1; @(negedge clk); irq_clr = 0;
                check(irq == 0, "R8 irq cleared", irq, 0);
                check(sb_q.size() == 0 && n_done == 11, "R9 outcome count", n_done, 11);
            end
            begin : wd
                repeat (150000) @(posedge clk);
                check(0, "watchdog timeout", cyc, 150000);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule